// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segmented memory request into a 20-bit physical address. It first forms a 16-bit offset by adding up to three terms. Each term has its own enable: a base register value, an index register value and a displacement. The sum wraps modulo 65536. When a short-displacement flag is set, the displacement is taken from its low 8 bits and sign-extended.

The block then chooses one of four segment register values. An access whose base term is enabled and comes from the stack-frame base register uses the stack segment. Every other access uses the data segment. An explicit override code replaces this default choice. The chosen segment is shifted left by four bit positions and added to the offset, and the 20-bit result wraps.

The physical address, the offset and the code of the chosen segment are registered together. A valid flag marks the cycle that follows each request. The block has no backpressure and holds its last result while no request is present.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, `out_valid` is 0 and `phys_addr`, `eff_addr` and `seg_code` are all 0.
- R2: `eff_addr` equals the sum of `base_val` (if `base_en`), `index_val` (if `index_en`) and the displacement (if `disp_en`), modulo 65536; a disabled term contributes zero.
- R3: With `disp_short` = 1, the displacement term is `disp_val[7:0]` sign-extended to 16 bits; with `disp_short` = 0 it is `disp_val` unchanged.
- R4: With `ovr_en` = 0, `base_en` = 1 and `base_is_bp` = 1, the stack segment is chosen (`seg_code` = 2, value `seg_ss`).
- R5: With `ovr_en` = 0 and no stack-frame base (either `base_en` = 0 or `base_is_bp` = 0), the data segment is chosen (`seg_code` = 3, value `seg_ds`), whatever the index term is.
- R6: With `ovr_en` = 1, the segment named by `ovr_code` is chosen, whatever the default would have been. The codes are 0 = `seg_es`, 1 = `seg_cs`, 2 = `seg_ss`, 3 = `seg_ds`.
- R7: `phys_addr` equals (chosen segment × 16 + `eff_addr`) modulo 2^20, so a high segment with a large offset rolls over into low memory.
- R8: The outputs take the result of a request on the clock edge at which `req_valid` is 1. `out_valid` is 1 in exactly the cycle after each request cycle. When `req_valid` is 0, `phys_addr`, `eff_addr` and `seg_code` keep their values.
- R9: `seg_code` reports the code (same encoding as R6) of the segment that was used for `phys_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| seg_cs | input | 16 | Code segment value |
| seg_ds | input | 16 | Data segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_es | input | 16 | Extra segment value |
| base_val | input | 16 | Base register value |
| base_en | input | 1 | Include the base term |
| base_is_bp | input | 1 | Base comes from the stack-frame base register |
| index_val | input | 16 | Index register value |
| index_en | input | 1 | Include the index term |
| disp_val | input | 16 | Displacement |
| disp_en | input | 1 | Include the displacement term |
| disp_short | input | 1 | Sign-extend the low 8 displacement bits |
| ovr_en | input | 1 | Segment override present |
| ovr_code | input | 2 | Override segment code |
| out_valid | output | 1 | Registered result is new this cycle |
| phys_addr | output | 20 | Registered physical address |
| eff_addr | output | 16 | Registered effective offset |
| seg_code | output | 2 | Registered code of the chosen segment |

## Verification
The hardest cases to reach are the two wrap boundaries. One is an offset sum that overflows 16 bits. The other is a segment near FFFFh whose shifted value plus offset passes 2^20. Both must occur together with negative short displacements, where sign extension turns a small byte into a subtraction. Directed requests set up each of these: base FFF0h with index 0020h, segment FFFFh with offset 0010h, and byte FCh on a base of 0100h. A long random phase then biases segment and register values toward the top of their range. It also mixes stack-frame bases, index-only forms and overrides, so that every default and override path meets both kinds of carry.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   localparam int SEL_W   = 2;
   localparam int NUM_SEG = 4;

   typedef enum logic [SEL_W-1:0] {
      SEG_ES = 2'd0,
      SEG_CS = 2'd1,
      SEG_SS = 2'd2,
      SEG_DS = 2'd3
   } seg_code_e;

endpackage

// File: rtl/sag_disp_ext.sv
module sag_disp_ext #(
   parameter int OFS_W   = 16,
   parameter int SHORT_W = 8
) (
   input  logic [OFS_W-1:0] disp_raw,
   input  logic             short_i,
   output logic [OFS_W-1:0] disp_o
);
   localparam int PAD_W = OFS_W - SHORT_W;

   generate
      if (SHORT_W < 1 || SHORT_W >= OFS_W) begin : g_bad_short
         $error("sag_disp_ext: SHORT_W must lie in 1..OFS_W-1");
      end
   endgenerate

   logic [OFS_W-1:0] sext;
   assign sext   = {{PAD_W{disp_raw[SHORT_W-1]}}, disp_raw[SHORT_W-1:0]};
   assign disp_o = short_i ? sext : disp_raw;
endmodule

// File: rtl/sag_offset_sum.sv
module sag_offset_sum #(
   parameter int OFS_W   = 16,
   parameter int SHORT_W = 8
) (
   input  logic [OFS_W-1:0] base_val,
   input  logic             base_en,
   input  logic [OFS_W-1:0] index_val,
   input  logic             index_en,
   input  logic [OFS_W-1:0] disp_val,
   input  logic             disp_en,
   input  logic             disp_short,
   output logic [OFS_W-1:0] ea
);
   logic [OFS_W-1:0] disp_x;
   logic [OFS_W-1:0] t_base, t_index, t_disp;

   sag_disp_ext #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_ext (
      .disp_raw (disp_val),
      .short_i  (disp_short),
      .disp_o   (disp_x)
   );

   always_comb begin
      t_base  = base_en  ? base_val  : '0;
      t_index = index_en ? index_val : '0;
      t_disp  = disp_en  ? disp_x    : '0;
      ea      = t_base + t_index + t_disp;   // wraps at OFS_W bits
   end
endmodule

// File: rtl/sag_seg_select.sv
module sag_seg_select
   import seg_addr_pkg::*;
#(
   parameter int SEG_W = 16
) (
   input  logic [NUM_SEG-1:0][SEG_W-1:0] seg_bank,
   input  logic                          base_en,
   input  logic                          base_is_bp,
   input  logic                          ovr_en,
   input  logic [SEL_W-1:0]              ovr_code,
   output logic [SEL_W-1:0]              code_o,
   output logic [SEG_W-1:0]              seg_o
);
   seg_code_e        dflt;
   logic [NUM_SEG-1:0] hit;

   always_comb begin
      dflt   = (base_en && base_is_bp) ? SEG_SS : SEG_DS;
      code_o = ovr_en ? ovr_code : dflt;
   end

   generate
      for (genvar g = 0; g < NUM_SEG; g++) begin : g_hit
         assign hit[g] = (code_o == SEL_W'(g));
      end
   endgenerate

   always_comb begin
      seg_o = '0;
      for (int k = 0; k < NUM_SEG; k++) begin
         seg_o = seg_o | (seg_bank[k] & {SEG_W{hit[k]}});
      end
   end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int SEG_W   = 16,
   parameter int OFS_W   = 16,
   parameter int SHIFT   = 4,
   parameter int SHORT_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [SEG_W-1:0]       seg_cs,
   input  logic [SEG_W-1:0]       seg_ds,
   input  logic [SEG_W-1:0]       seg_ss,
   input  logic [SEG_W-1:0]       seg_es,
   input  logic [OFS_W-1:0]       base_val,
   input  logic                   base_en,
   input  logic                   base_is_bp,
   input  logic [OFS_W-1:0]       index_val,
   input  logic                   index_en,
   input  logic [OFS_W-1:0]       disp_val,
   input  logic                   disp_en,
   input  logic                   disp_short,
   input  logic                   ovr_en,
   input  logic [SEL_W-1:0]       ovr_code,
   output logic                   out_valid,
   output logic [SEG_W+SHIFT-1:0] phys_addr,
   output logic [OFS_W-1:0]       eff_addr,
   output logic [SEL_W-1:0]       seg_code
);
   localparam int PA_W  = SEG_W + SHIFT;
   localparam int EXT_W = PA_W - OFS_W;

   generate
      if (SHIFT < 1) begin : g_bad_shift
         $error("seg_addr_gen: SHIFT must be at least 1");
      end
      if (OFS_W >= PA_W) begin : g_bad_ofs
         $error("seg_addr_gen: OFS_W must be narrower than SEG_W+SHIFT");
      end
   endgenerate

   logic [OFS_W-1:0]                ea_nx;
   logic [SEL_W-1:0]                code_nx;
   logic [SEG_W-1:0]                seg_nx;
   logic [PA_W-1:0]                 phys_nx;
   logic [NUM_SEG-1:0][SEG_W-1:0]   bank;

   always_comb begin
      bank[SEG_ES] = seg_es;
      bank[SEG_CS] = seg_cs;
      bank[SEG_SS] = seg_ss;
      bank[SEG_DS] = seg_ds;
   end

   sag_offset_sum #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_sum (
      .base_val   (base_val),
      .base_en    (base_en),
      .index_val  (index_val),
      .index_en   (index_en),
      .disp_val   (disp_val),
      .disp_en    (disp_en),
      .disp_short (disp_short),
      .ea         (ea_nx)
   );

   sag_seg_select #(.SEG_W(SEG_W)) u_sel (
      .seg_bank   (bank),
      .base_en    (base_en),
      .base_is_bp (base_is_bp),
      .ovr_en     (ovr_en),
      .ovr_code   (ovr_code),
      .code_o     (code_nx),
      .seg_o      (seg_nx)
   );

   // shifted segment plus zero-extended offset; carry out of PA_W is dropped
   assign phys_nx = {seg_nx, {SHIFT{1'b0}}} + {{EXT_W{1'b0}}, ea_nx};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         phys_addr <= '0;
         eff_addr  <= '0;
         seg_code  <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            phys_addr <= phys_nx;
            eff_addr  <= ea_nx;
            seg_code  <= code_nx;
         end
      end
   end

   AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);                                          // R8
   AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid);                                        // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(phys_addr) && $stable(eff_addr) && $stable(seg_code))); // R8
   AST_BP_TO_SS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !ovr_en && base_en && base_is_bp) |=> (seg_code == SEG_SS)); // R4
   AST_PLAIN_TO_DS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !ovr_en && !(base_en && base_is_bp)) |=> (seg_code == SEG_DS)); // R5
   AST_OVR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ovr_en) |=> (seg_code == $past(ovr_code)));           // R6
   AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (phys_addr[SHIFT-1:0] == eff_addr[SHIFT-1:0]));       // R7
endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] seg_cs = '0, seg_ds = '0, seg_ss = '0, seg_es = '0;
   logic [15:0] base_val = '0, index_val = '0, disp_val = '0;
   logic        base_en = 0, base_is_bp = 0, index_en = 0, disp_en = 0, disp_short = 0;
   logic        ovr_en = 0;
   logic [1:0]  ovr_code = '0;
   logic        out_valid;
   logic [19:0] phys_addr;
   logic [15:0] eff_addr;
   logic [1:0]  seg_code;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   bit          m_valid = 0;
   int unsigned m_phys = 0, m_eff = 0, m_code = 0;

   always #5 clk = ~clk;

   seg_addr_gen u_seg_addr_gen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .seg_cs(seg_cs), .seg_ds(seg_ds), .seg_ss(seg_ss), .seg_es(seg_es),
      .base_val(base_val), .base_en(base_en), .base_is_bp(base_is_bp),
      .index_val(index_val), .index_en(index_en),
      .disp_val(disp_val), .disp_en(disp_en), .disp_short(disp_short),
      .ovr_en(ovr_en), .ovr_code(ovr_code),
      .out_valid(out_valid), .phys_addr(phys_addr),
      .eff_addr(eff_addr), .seg_code(seg_code)
   );

   task automatic check(string req, int unsigned act, int unsigned exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int unsigned model_ea();
      int unsigned s = 0, d;
      if (base_en)  s += base_val;
      if (index_en) s += index_val;
      if (disp_en) begin
         d = disp_val;
         if (disp_short) d = (disp_val[7] ? 32'hFF00 : 0) + disp_val[7:0];
         s += d;
      end
      return s % 65536;
   endfunction

   function automatic int unsigned model_code();
      if (ovr_en) return ovr_code;
      if (base_en && base_is_bp) return 2;
      return 3;
   endfunction

   function automatic int unsigned seg_of(int unsigned c);
      case (c)
         0: return seg_es;
         1: return seg_cs;
         2: return seg_ss;
         default: return seg_ds;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 0; m_phys = 0; m_eff = 0; m_code = 0;
      end else begin
         m_valid = req_valid;
         if (req_valid) begin
            m_eff  = model_ea();
            m_code = model_code();
            m_phys = (seg_of(m_code) * 16 + m_eff) % 32'h100000;
         end
      end
   end

   // cycle-by-cycle comparison
   always @(negedge clk) begin
      if (rst_n) begin
         check("R8 out_valid", out_valid, m_valid);
         check("R2 eff_addr", eff_addr, m_eff);
         check("R9 seg_code", seg_code, m_code);
         check("R7 phys_addr", phys_addr, m_phys);
      end
   end

   task automatic clear_req();
      req_valid = 0; base_en = 0; base_is_bp = 0; index_en = 0;
      disp_en = 0; disp_short = 0; ovr_en = 0; ovr_code = 0;
   endtask

   // drive at a falling edge, result visible at the next falling edge
   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1 out_valid", out_valid, 0);
      check("R1 phys_addr", phys_addr, 0);
      check("R1 eff_addr", eff_addr, 0);
      check("R1 seg_code", seg_code, 0);
      rst_n = 1;
      seg_cs = 16'h0F00; seg_ds = 16'h1000; seg_ss = 16'h2000; seg_es = 16'hB800;

      // R2: base + index + disp = 0300+0010+4 -> 0314, DS -> 10314
      step(); clear_req(); req_valid = 1;
      base_en = 1; base_val = 16'h0300; index_en = 1; index_val = 16'h0010;
      disp_en = 1; disp_val = 16'h0004;
      step(); clear_req();
      check("R2 sum", eff_addr, 16'h0314);
      check("R5 bx default ds", seg_code, 3);
      check("R7 phys", phys_addr, 20'h10314);

      // R8: idle cycle holds
      step();
      check("R8 no valid idle", out_valid, 0);
      check("R8 hold phys", phys_addr, 20'h10314);

      // R3: short disp FC on base 0100 -> 00FC
      req_valid = 1; base_en = 1; base_val = 16'h0100; disp_en = 1;
      disp_short = 1; disp_val = 16'h12FC;
      step(); clear_req();
      check("R3 short negative", eff_addr, 16'h00FC);

      // R3: long disp taken whole
      req_valid = 1; disp_en = 1; disp_val = 16'h12FC;
      step(); clear_req();
      check("R3 long disp", eff_addr, 16'h12FC);

      // R4: BP base -> SS
      req_valid = 1; base_en = 1; base_is_bp = 1; base_val = 16'h0FFE;
      step(); clear_req();
      check("R4 bp uses ss", seg_code, 2);
      check("R4 phys", phys_addr, 20'h20FFE);

      // R5: index only, even with bp flag but base disabled -> DS
      req_valid = 1; base_is_bp = 1; index_en = 1; index_val = 16'h0040;
      step(); clear_req();
      check("R5 index only ds", seg_code, 3);

      // R6: ES override on DI-style access, and override beats BP default
      req_valid = 1; index_en = 1; index_val = 16'h0000; ovr_en = 1; ovr_code = 0;
      step(); clear_req();
      check("R6 es override", seg_code, 0);
      check("R6 es phys", phys_addr, 20'hB8000);
      req_valid = 1; base_en = 1; base_is_bp = 1; base_val = 16'h0002; ovr_en = 1; ovr_code = 1;
      step(); clear_req();
      check("R6 cs over bp", seg_code, 1);

      // R2: 16-bit wrap FFF0+0020 -> 0010
      req_valid = 1; base_en = 1; base_val = 16'hFFF0; index_en = 1; index_val = 16'h0020;
      step(); clear_req();
      check("R2 offset wrap", eff_addr, 16'h0010);

      // R7: FFFF:0010 rolls to 00000
      seg_ds = 16'hFFFF;
      req_valid = 1; disp_en = 1; disp_val = 16'h0010;
      step(); clear_req();
      check("R7 phys wrap", phys_addr, 20'h00000);

      // random phase, checked by the model every cycle
      for (int i = 0; i < 4000; i++) begin
         req_valid  = ($urandom % 4) != 0;
         seg_cs = $urandom; seg_ds = ($urandom % 2) ? 16'hFFFF - ($urandom % 64) : $urandom;
         seg_ss = ($urandom % 2) ? 16'hFFF0 + ($urandom % 16) : $urandom;
         seg_es = $urandom;
         base_val  = ($urandom % 2) ? 16'hFFFF - ($urandom % 256) : $urandom;
         index_val = $urandom; disp_val = $urandom;
         base_en = $urandom; base_is_bp = $urandom; index_en = $urandom;
         disp_en = $urandom; disp_short = $urandom;
         ovr_en = ($urandom % 3) == 0; ovr_code = $urandom;
         step();
      end
      clear_req();
      step(); step();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule